// File: doc/BRIEF.md
# Split Divide-by-Two / Divide-by-Five Decade Counter

This block is a four-bit counter made of two sections that count independently. A one-bit divide-by-two section is advanced by its own count input. A three-bit divide-by-five section is advanced by a second count input. When the user feeds the least significant output back into the second count input, the pair forms a decade counter that steps 0 to 9 in BCD and returns to 0 on the tenth pulse. Each section can also serve alone as a modulo-2 or modulo-5 divider.

The count inputs are treated as slow signals. They are sampled by the fast system clock through a synchronizer, and a falling edge is detected inside the block, so all state changes happen on the system clock. Two gated level controls act on the whole counter. One pair of inputs clears it to zero. A second pair of inputs presets it to nine, and the preset takes priority over the clear.

Top module: `decade_split_counter`

## Requirements
- R1: While rst_ni is low, all four outputs are 0.
- R2: qa_o toggles once for each falling edge of cnt_a_i. A rising edge of cnt_a_i has no effect.
- R3: {qd_o,qc_o,qb_o}, with qb_o as the LSB, steps through binary 0,1,2,3,4 on each falling edge of cnt_b_i and wraps from 4 to 0. It never holds 5, 6 or 7.
- R4: The sections are independent. Edges on cnt_a_i never change qb_o..qd_o, and edges on cnt_b_i never change qa_o.
- R5: With qa_o wired to cnt_b_i, successive falling edges on cnt_a_i give the BCD sequence 0..9 on {qd_o,qc_o,qb_o,qa_o}, and the tenth edge returns the count to 0. This includes 9 to 0.
- R6: When clr0_i and clr1_i are both high and set0_i and set1_i are not both high, the outputs become 0000 at the next clock edge. They hold 0000 while the condition lasts, and count edges are ignored.
- R7: When set0_i and set1_i are both high, the outputs become 1001 at the next clock edge and hold there whatever the clear inputs and count edges do.
- R8: A single clear input high, or a single set input high, has no effect, and counting continues normally.
- R9: An output driven by a falling count edge changes on the third rising clock edge after the count input falls, with the default two synchronizer stages. Each count level must last at least three clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples every input |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_a_i | input | 1 | Count input of the divide-by-two section |
| cnt_b_i | input | 1 | Count input of the divide-by-five section |
| clr0_i | input | 1 | Clear-to-zero control, first of the pair |
| clr1_i | input | 1 | Clear-to-zero control, second of the pair |
| set0_i | input | 1 | Preset-to-nine control, first of the pair |
| set1_i | input | 1 | Preset-to-nine control, second of the pair |
| qa_o | output | 1 | Divide-by-two output, count LSB |
| qb_o | output | 1 | Divide-by-five output, bit 0 |
| qc_o | output | 1 | Divide-by-five output, bit 1 |
| qd_o | output | 1 | Divide-by-five output, bit 2, count MSB |

## Verification
The hardest case to reach is the decade chain crossing 9 to 0 right after a preset. In that case a falling edge of qa_o must travel back through the second synchronizer while the divide-by-five section sits at its top value. The bench drives this case directly: it asserts both preset inputs together with both clear inputs, releases them, and then pulses the A input with qa_o looped to the B input. Random runs then mix single-section pulses with partial and full control patterns, so that held controls meet pending count edges.

// File: rtl/dsc_pkg.sv
`timescale 1ns/1ps
package dsc_pkg;
  typedef enum logic [1:0] {
    CTRL_RUN = 2'd0,
    CTRL_CLR = 2'd1,
    CTRL_SET = 2'd2
  } ctrl_e;

  localparam int unsigned DIV5_W = 3;
  localparam logic [DIV5_W-1:0] DIV5_LAST = 3'd4;
  localparam logic [DIV5_W-1:0] DIV5_SET  = 3'd4;
  localparam logic              DIV2_SET  = 1'b1;

  // preset pair wins over clear pair
  function automatic ctrl_e ctrl_decode(input logic c0, input logic c1,
                                        input logic s0, input logic s1);
    if (s0 && s1) return CTRL_SET;
    if (c0 && c1) return CTRL_CLR;
    return CTRL_RUN;
  endfunction

  // illegal codes above DIV5_LAST fall back to zero
  function automatic logic [DIV5_W-1:0] div5_next(input logic [DIV5_W-1:0] q);
    if (q >= DIV5_LAST) return '0;
    return q + {{(DIV5_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/dsc_fall_det.sv
`timescale 1ns/1ps
module dsc_fall_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic fall_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[LAST];
    end
  end

  assign fall_o = prev_q & ~sync_q[LAST];
endmodule

// File: rtl/dsc_div2.sv
`timescale 1ns/1ps
module dsc_div2
  import dsc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ctrl_e ctrl_i,
  input  logic  step_i,
  output logic  q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= 1'b0;
    end else begin
      unique case (ctrl_i)
        CTRL_SET: q_o <= DIV2_SET;
        CTRL_CLR: q_o <= 1'b0;
        default:  if (step_i) q_o <= ~q_o;
      endcase
    end
  end
endmodule

// File: rtl/dsc_div5.sv
`timescale 1ns/1ps
module dsc_div5
  import dsc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_e             ctrl_i,
  input  logic              step_i,
  output logic [DIV5_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else begin
      unique case (ctrl_i)
        CTRL_SET: q_o <= DIV5_SET;
        CTRL_CLR: q_o <= '0;
        default:  if (step_i) q_o <= div5_next(q_o);
      endcase
    end
  end
endmodule

// File: rtl/decade_split_counter.sv
`timescale 1ns/1ps
module decade_split_counter
  import dsc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cnt_a_i,
  input  logic cnt_b_i,
  input  logic clr0_i,
  input  logic clr1_i,
  input  logic set0_i,
  input  logic set1_i,
  output logic qa_o,
  output logic qb_o,
  output logic qc_o,
  output logic qd_o
);
  localparam int unsigned NSEC = 2;

  logic [NSEC-1:0]   cnt_in;
  logic [NSEC-1:0]   fall;
  ctrl_e             ctrl;
  logic [DIV5_W-1:0] hi_q;

  assign cnt_in = {cnt_b_i, cnt_a_i};
  assign ctrl   = ctrl_decode(clr0_i, clr1_i, set0_i, set1_i);

  for (genvar g = 0; g < NSEC; g++) begin : g_edge
    dsc_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (cnt_in[g]),
      .fall_o (fall[g])
    );
  end

  dsc_div2 u_lo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctrl_i (ctrl),
    .step_i (fall[0]),
    .q_o    (qa_o)
  );

  dsc_div5 u_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctrl_i (ctrl),
    .step_i (fall[1]),
    .q_o    (hi_q)
  );

  assign {qd_o, qc_o, qb_o} = hi_q;
endmodule

// File: rtl/dsc_chk.sv
`timescale 1ns/1ps
module dsc_chk #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cnt_a_i,
  input logic cnt_b_i,
  input logic clr0_i,
  input logic clr1_i,
  input logic set0_i,
  input logic set1_i,
  input logic qa_o,
  input logic qb_o,
  input logic qc_o,
  input logic qd_o
);
  localparam int unsigned LAG = SYNC_STAGES + 2;

  logic       set_all, clr_all;
  logic [2:0] hi;
  logic [3:0] q;
  assign set_all = set0_i & set1_i;
  assign clr_all = clr0_i & clr1_i;
  assign hi      = {qd_o, qc_o, qb_o};
  assign q       = {qd_o, qc_o, qb_o, qa_o};

  // R2
  lo_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qa_o != $past(qa_o) && !$past(set_all) && !$past(clr_all))
      |-> ($past(cnt_a_i, LAG) && !$past(cnt_a_i, LAG-1)));

  // R3
  hi_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(qd_o && (qc_o || qb_o)));

  // R4
  hi_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi != $past(hi) && !$past(set_all) && !$past(clr_all))
      |-> ($past(cnt_b_i, LAG) && !$past(cnt_b_i, LAG-1)));

  // R6
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_all && !set_all) |=> (q == 4'b0000));

  // R7
  preset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_all |=> (q == 4'b1001));
endmodule

bind decade_split_counter dsc_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cnt_a_i (cnt_a_i),
  .cnt_b_i (cnt_b_i),
  .clr0_i  (clr0_i),
  .clr1_i  (clr1_i),
  .set0_i  (set0_i),
  .set1_i  (set1_i),
  .qa_o    (qa_o),
  .qb_o    (qb_o),
  .qc_o    (qc_o),
  .qd_o    (qd_o)
);

// File: tb/sim_decade_split_counter.sv
`timescale 1ns/1ps
module sim_decade_split_counter;
  localparam time TCK = 20ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic a_drv = 1'b0, b_drv = 1'b0, chain = 1'b0;
  logic c0 = 1'b0, c1 = 1'b0, s0 = 1'b0, s1 = 1'b0;
  logic qa, qb, qc, qd, cnt_b;
  int   vec = 0, bad = 0;
  logic       m_a = 1'b0;
  logic [2:0] m_b = 3'd0;

  assign cnt_b = chain ? qa : b_drv;
  always #(TCK/2) clk = ~clk;

  decade_split_counter u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_a_i(a_drv), .cnt_b_i(cnt_b),
    .clr0_i(c0), .clr1_i(c1), .set0_i(s0), .set1_i(s1),
    .qa_o(qa), .qb_o(qb), .qc_o(qc), .qd_o(qd)
  );

  function automatic logic [2:0] nxt5(input logic [2:0] v);
    return (v == 3'd4) ? 3'd0 : v + 3'd1;
  endfunction

  function automatic bit held();
    return (s0 && s1) || (c0 && c1);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] exp);
    vec++;
    if ({qd, qc, qb, qa} !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, {qd, qc, qb, qa}, exp);
    end
  endtask

  task automatic set_ctrl(input string req, input logic x0, input logic x1,
                          input logic y0, input logic y1);
    c0 = x0; c1 = x1; s0 = y0; s1 = y1;
    if (y0 && y1) begin m_a = 1'b1; m_b = 3'd4; end
    else if (x0 && x1) begin m_a = 1'b0; m_b = 3'd0; end
    idle(2);
    check(req, {m_b, m_a});
  endtask

  task automatic pulse_a(input string req);
    logic old;
    a_drv = 1'b1;
    idle(4);
    check(req, {m_b, m_a});  // rising edge leaves outputs alone
    a_drv = 1'b0;
    idle(chain ? 9 : 5);
    if (!held()) begin
      old = m_a;
      m_a = ~m_a;
      if (chain && old) m_b = nxt5(m_b);
    end
    check(req, {m_b, m_a});
  endtask

  task automatic pulse_b(input string req);
    b_drv = 1'b1;
    idle(4);
    check(req, {m_b, m_a});
    b_drv = 1'b0;
    idle(5);
    if (!held()) m_b = nxt5(m_b);
    check(req, {m_b, m_a});
  endtask

  initial begin
    #(TCK * 150000);
    bad++; vec++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    idle(3);
    check("R1", 4'b0000);
    rst_n = 1'b1;
    idle(2);

    // R9 latency: fall driven at a negedge, visible after third posedge
    a_drv = 1'b1; idle(4);
    a_drv = 1'b0; idle(2);
    check("R9", 4'b0000);
    idle(1);
    check("R9", 4'b0001);
    m_a = 1'b1;
    idle(4);
    pulse_a("R2");
    for (int i = 0; i < 6; i++) pulse_b("R3");
    pulse_a("R4");
    pulse_b("R4");

    // decade chain
    set_ctrl("R6", 1, 1, 0, 0);
    set_ctrl("R6", 0, 0, 0, 0);
    chain = 1'b1;
    for (int i = 0; i < 10; i++) pulse_a("R5");
    check("R5", 4'b0000);
    set_ctrl("R7", 1, 1, 1, 1);
    pulse_a("R7");
    set_ctrl("R7", 0, 0, 0, 0);
    pulse_a("R5");  // 9 -> 0
    pulse_a("R5");
    set_ctrl("R6", 1, 1, 0, 1);
    pulse_a("R6");
    set_ctrl("R8", 1, 0, 0, 1);
    pulse_a("R8");
    set_ctrl("R8", 0, 1, 1, 0);
    pulse_a("R8");
    set_ctrl("R6", 1, 1, 0, 0);
    set_ctrl("R6", 0, 0, 0, 0);
    chain = 1'b0;

    // random mix, independent sections
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 8);
      if (op < 3) pulse_a("R2");
      else if (op < 6) pulse_b("R3");
      else if (op == 6) begin
        if ($urandom % 2) set_ctrl("R8", 1, 0, 0, 0);
        else set_ctrl("R8", 0, 0, 0, 1);
        if ($urandom % 2) pulse_a("R8"); else pulse_b("R8");
        set_ctrl("R8", 0, 0, 0, 0);
      end else begin
        if ($urandom % 2) set_ctrl("R7", $urandom % 2, $urandom % 2, 1, 1);
        else set_ctrl("R6", 1, 1, 0, 0);
        if ($urandom % 2) pulse_a("R6"); else pulse_b("R7");
        set_ctrl("R8", 0, 0, 0, 0);
      end
    end

    rst_n = 1'b0;
    idle(1);
    check("R1", 4'b0000);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule